// File: doc/BRIEF.md
# Addressed SPI Register-Map Slave

This block is an SPI mode-0 slave, addressed by pins, that exposes a 64-byte map. The lower 56 bytes are general-purpose storage. The top 8-byte page holds the control registers: a 12-bit DAC code split over two bytes, a non-volatile initial DAC code reached through the same two bytes, a range/stepping configuration byte, and a volatile selector bit that chooses which of the two DAC codes those bytes reach. The SPI pins are brought into the system clock domain through synchronizer chains. All protocol decoding runs on that clock.

Each transaction opens with an identification byte. Bit 7 of that byte selects a status poll. Bits 6:1 carry a device address that is compared with the address pins. Bit 0 selects read (1) or write (0). A memory address byte follows. A read streams bytes from an auto-incrementing pointer that wraps around the whole map. A write collects up to a page of bytes in a staging buffer. The staging buffer is committed only when chip select rises after whole bytes. Writes to storage, to the configuration byte or to the initial DAC code start a self-timed busy period of `NV_WRITE_CYCLES` clocks. The status poll reports this busy period.

Top module: `spi_regmap_slave`

## Requirements
- R1: After reset, `dac_code` is 000h, `cfg_byte` is 84h, the selector bit is 0, and `spi_miso_oe` is 0.
- R2: `spi_mosi` is taken MSB first on rising `spi_sck` edges, and only while `spi_csn` is low and `not_ready` is low. Edges seen while `not_ready` is high are ignored, so a command sent then changes nothing. `spi_miso` changes after falling edges. `spi_miso_oe` is 0 whenever `spi_csn` is high.
- R3: If identification bits 6:1 differ from `dev_addr`, the command is ignored. An identification byte with bit 7 set is a status poll.
- R4: A memory address byte above 3Fh aborts the command, and nothing is written.
- R5: Read data starts on the first falling edge after the last address bit. The pointer increments once per byte, and 3Fh is followed by 00h.
- R6: Write bytes land at addresses that wrap inside the 8-byte page of the start address. Any byte past the eighth overwrites an earlier one. Nothing is stored unless `spi_csn` rises on a whole-byte boundary.
- R7: A write of exactly two bytes starting at 38h loads the DAC code. 38h carries bits 11:4 and the upper nibble of 39h carries bits 3:0. The lower nibble of 39h reads back as 0. Any other write that touches 38h or 39h is discarded.
- R8: A single byte of 80h written to 3Fh sets the selector, 00h clears it, and any other value is discarded. 3Fh reads back as {selector, 7'b0}. While the selector is 1, 38h and 39h reach the initial DAC code and `dac_code` is unaffected.
- R9: A single byte written to 3Ch loads `cfg_byte`. The write is discarded if bits 7:5 or bits 4:2 hold 110 or 111, if bits 1:0 hold 11, or if the write has more than one byte.
- R10: Writes to 3Ah, 3Bh, 3Dh and 3Eh are discarded, and those bytes read back as 00h.
- R11: A committed write to storage, to 3Ch, or to 38h/39h while the selector is 1 raises the busy flag for `NV_WRITE_CYCLES` clocks. Volatile writes do not raise it.
- R12: A status poll returns {7'b0, busy} in every byte that follows the identification byte.
- R13: While busy is set, write commands are ignored, but reads and polls are still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock (mode 0) |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (tri-state control) |
| dev_addr | input | 6 | Device address pins compared with identification bits 6:1 |
| not_ready | input | 1 | High while the device is not ready; the bus is ignored |
| dac_code | output | 12 | Volatile DAC code |
| cfg_byte | output | 8 | Configuration byte: full-scale code 7:5, zero-scale code 4:2, step size 1:0 |

## Verification
An SPI pin edge reaches the protocol logic after the synchronizer stages plus one edge-detect register. `spi_miso` therefore settles about four clocks after a falling `spi_sck`. `dac_code` and `cfg_byte` settle about four clocks after `spi_csn` rises, and storage commits within eight further clocks. The bench holds each SCK phase for eight clocks. It samples `spi_miso` just before the next rising edge, and it reads outputs or the map at least twenty clocks after `spi_csn` rises, so every result is already stable when it is checked. The busy period is observed with a poll issued right after a commit and with a second poll issued after `NV_WRITE_CYCLES` plus a margin.

// File: rtl/rms_pkg.sv
package rms_pkg;
  localparam int BYTE_W     = 8;
  localparam int MAP_AW     = 6;
  localparam int PAGE_AW    = 3;
  localparam int PG_W       = MAP_AW - PAGE_AW;
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int NUM_PAGES  = 1 << PG_W;
  localparam int GPM_BYTES  = (NUM_PAGES - 1) * PAGE_BYTES;
  localparam int DAC_W      = 12;
  localparam int ID_ADDR_W  = 6;

  localparam logic [PG_W-1:0]   CTRL_PG  = '1;
  localparam logic [MAP_AW-1:0] A_DAC_HI = 6'h38;
  localparam logic [MAP_AW-1:0] A_DAC_LO = 6'h39;
  localparam logic [MAP_AW-1:0] A_CFG    = 6'h3C;
  localparam logic [MAP_AW-1:0] A_SEL    = 6'h3F;
  localparam logic [BYTE_W-1:0] CFG_DEFAULT = 8'h84;
  localparam logic [BYTE_W-1:0] SEL_ON      = 8'h80;
  localparam logic [BYTE_W-1:0] SEL_OFF     = 8'h00;

  typedef enum logic [2:0] {
    PH_ID, PH_ADDR, PH_WDATA, PH_RDATA, PH_POLL, PH_DROP
  } phase_t;

  // Range codes 110/111 and step code 11 are not legal
  function automatic logic cfg_code_ok(input logic [BYTE_W-1:0] b);
    return (b[7:5] <= 3'd5) && (b[4:2] <= 3'd5) && (b[1:0] != 2'b11);
  endfunction
endpackage

// File: rtl/rms_spi_front.sv
module rms_spi_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_pin,
  input  logic csn_pin,
  input  logic mosi_pin,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_on,
  output logic cs_end,
  output logic mosi_s
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] RST_VAL = 3'b010; // {sck, csn, mosi}

  logic [NPIN-1:0] pins;
  logic [NPIN-1:0] synced;
  logic            sck_d, csn_d;

  assign pins = {sck_pin, csn_pin, mosi_pin};

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [STAGES-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= {STAGES{RST_VAL[i]}};
      else     q <= {q[STAGES-2:0], pins[i]};
    end
    assign synced[i] = q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_d <= synced[2];
      csn_d <= synced[1];
    end
  end

  assign sck_rise = synced[2] & ~sck_d;
  assign sck_fall = ~synced[2] & sck_d;
  assign cs_on    = ~synced[1];
  assign cs_end   = synced[1] & ~csn_d;
  assign mosi_s   = synced[0];
endmodule

// File: rtl/rms_gpm.sv
module rms_gpm #(
  parameter int DEPTH = 56,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = (raddr <= LAST) ? mem[raddr] : '0;
endmodule

// File: rtl/rms_busy_timer.sv
module rms_busy_timer #(
  parameter int CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)              left <= '0;
    else if (start)       left <= CW'(CYCLES);
    else if (left != '0)  left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/spi_regmap_slave.sv
module spi_regmap_slave
  import rms_pkg::*;
#(
  parameter int NV_WRITE_CYCLES = 2_500_000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 spi_sck,
  input  logic                 spi_csn,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  output logic                 spi_miso_oe,
  input  logic [ID_ADDR_W-1:0] dev_addr,
  input  logic                 not_ready,
  output logic [DAC_W-1:0]     dac_code,
  output logic [BYTE_W-1:0]    cfg_byte
);
  localparam logic [3:0] CNT_SAT = 4'(PAGE_BYTES + 1);

  logic sck_rise, sck_fall, cs_on, cs_end, mosi_s;

  rms_spi_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .sck_pin(spi_sck), .csn_pin(spi_csn), .mosi_pin(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_on(cs_on), .cs_end(cs_end), .mosi_s(mosi_s)
  );

  phase_t                            phase;
  logic [6:0]                        rx_sh;
  logic [2:0]                        rx_cnt;
  logic                              is_rd;
  logic [MAP_AW-1:0]                 ptr, wr_start;
  logic [3:0]                        wr_cnt;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0] stage;
  logic [PAGE_BYTES-1:0]             stage_mask;
  logic [BYTE_W-1:0]                 tx_sh;
  logic [2:0]                        tx_cnt;
  logic                              wip, sel;
  logic [DAC_W-1:0]                  nv_dac;

  logic              rx_en, tx_en, byte_done, id_match;
  logic [BYTE_W-1:0] rx_byte, rd_byte, tx_next, gpm_rdata;

  assign rx_en     = sck_rise & cs_on & ~not_ready;
  assign tx_en     = sck_fall & cs_on & ~not_ready;
  assign rx_byte   = {rx_sh, mosi_s};
  assign byte_done = rx_en && (rx_cnt == 3'd7);
  assign id_match  = (rx_byte[6:1] == dev_addr);

  // ---------------- read mux ----------------
  logic [DAC_W-1:0] dac_view;
  assign dac_view = sel ? nv_dac : dac_code;

  always_comb begin
    rd_byte = '0;
    if (ptr[MAP_AW-1:PAGE_AW] != CTRL_PG) rd_byte = gpm_rdata;
    else begin
      case (ptr)
        A_DAC_HI: rd_byte = dac_view[DAC_W-1:4];
        A_DAC_LO: rd_byte = {dac_view[3:0], 4'b0000};
        A_CFG:    rd_byte = cfg_byte;
        A_SEL:    rd_byte = {sel, 7'b0};
        default:  rd_byte = '0;
      endcase
    end
  end

  assign tx_next = (phase == PH_POLL) ? {7'b0, wip} : rd_byte;

  // ---------------- commit decode ----------------
  logic commit_go, is_ctrl, dac_ok, cfg_ok, sel_ok, gpm_ok, nv_start;

  assign commit_go = cs_end && (phase == PH_WDATA) && (rx_cnt == 3'd0) && (wr_cnt != 4'd0);
  assign is_ctrl   = (wr_start[MAP_AW-1:PAGE_AW] == CTRL_PG);
  assign dac_ok    = commit_go && is_ctrl && (wr_start == A_DAC_HI) && (wr_cnt == 4'd2);
  assign cfg_ok    = commit_go && is_ctrl && (wr_start == A_CFG) && (wr_cnt == 4'd1) &&
                     cfg_code_ok(stage[A_CFG[PAGE_AW-1:0]]);
  assign sel_ok    = commit_go && is_ctrl && (wr_start == A_SEL) && (wr_cnt == 4'd1) &&
                     ((stage[A_SEL[PAGE_AW-1:0]] == SEL_ON) || (stage[A_SEL[PAGE_AW-1:0]] == SEL_OFF));
  assign gpm_ok    = commit_go && !is_ctrl;
  assign nv_start  = gpm_ok || cfg_ok || (dac_ok && sel);

  // ---------------- protocol engine ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_ID;
      rx_sh       <= '0;
      rx_cnt      <= '0;
      is_rd       <= 1'b0;
      ptr         <= '0;
      wr_start    <= '0;
      wr_cnt      <= '0;
      stage       <= '0;
      stage_mask  <= '0;
      tx_sh       <= '0;
      tx_cnt      <= '0;
      spi_miso    <= 1'b0;
      spi_miso_oe <= 1'b0;
    end else if (!cs_on) begin
      phase       <= PH_ID;
      rx_cnt      <= '0;
      tx_cnt      <= '0;
      spi_miso_oe <= 1'b0;
    end else begin
      if (rx_en) begin
        rx_sh  <= rx_byte[6:0];
        rx_cnt <= rx_cnt + 3'd1;
      end
      if (byte_done) begin
        case (phase)
          PH_ID: begin
            is_rd <= rx_byte[0];
            if (rx_byte[7])                                   phase <= id_match ? PH_POLL : PH_DROP;
            else if (id_match && (rx_byte[0] || !wip))        phase <= PH_ADDR;
            else                                              phase <= PH_DROP;
          end
          PH_ADDR: begin
            if (rx_byte[7:6] != 2'b00) phase <= PH_DROP;
            else begin
              ptr        <= rx_byte[MAP_AW-1:0];
              wr_start   <= rx_byte[MAP_AW-1:0];
              wr_cnt     <= '0;
              stage_mask <= '0;
              phase      <= is_rd ? PH_RDATA : PH_WDATA;
            end
          end
          PH_WDATA: begin
            stage[ptr[PAGE_AW-1:0]]      <= rx_byte;
            stage_mask[ptr[PAGE_AW-1:0]] <= 1'b1;
            ptr[PAGE_AW-1:0]             <= ptr[PAGE_AW-1:0] + 1'b1;
            if (wr_cnt != CNT_SAT) wr_cnt <= wr_cnt + 4'd1;
          end
          default: ;
        endcase
      end
      if (tx_en && (phase == PH_RDATA || phase == PH_POLL)) begin
        if (tx_cnt == 3'd0) begin
          spi_miso <= tx_next[7];
          tx_sh    <= {tx_next[6:0], 1'b0};
          if (phase == PH_RDATA) ptr <= ptr + 1'b1;
        end else begin
          spi_miso <= tx_sh[7];
          tx_sh    <= {tx_sh[6:0], 1'b0};
        end
        tx_cnt      <= tx_cnt + 3'd1;
        spi_miso_oe <= 1'b1;
      end
    end
  end

  // ---------------- control registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code <= '0;
      nv_dac   <= '0;
      cfg_byte <= CFG_DEFAULT;
      sel      <= 1'b0;
    end else begin
      if (dac_ok && !sel) dac_code <= {stage[0], stage[1][7:4]};
      if (dac_ok && sel)  nv_dac   <= {stage[0], stage[1][7:4]};
      if (cfg_ok)         cfg_byte <= stage[A_CFG[PAGE_AW-1:0]];
      if (sel_ok)         sel      <= stage[A_SEL[PAGE_AW-1:0]][7];
    end
  end

  // ---------------- storage commit, one byte per clock ----------------
  logic                  eng_run;
  logic [PAGE_AW-1:0]    eng_idx;
  logic [PG_W-1:0]       eng_page;
  logic [PAGE_BYTES-1:0] eng_mask;
  logic                  gpm_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_run  <= 1'b0;
      eng_idx  <= '0;
      eng_page <= '0;
      eng_mask <= '0;
    end else if (gpm_ok) begin
      eng_run  <= 1'b1;
      eng_idx  <= '0;
      eng_page <= wr_start[MAP_AW-1:PAGE_AW];
      eng_mask <= stage_mask;
    end else if (eng_run) begin
      eng_idx <= eng_idx + 1'b1;
      if (eng_idx == '1) eng_run <= 1'b0;
    end
  end

  assign gpm_we = eng_run && eng_mask[eng_idx];

  rms_gpm #(.DEPTH(GPM_BYTES), .AW(MAP_AW), .DW(BYTE_W)) u_gpm (
    .clk(clk), .we(gpm_we), .waddr({eng_page, eng_idx}), .wdata(stage[eng_idx]),
    .raddr(ptr), .rdata(gpm_rdata)
  );

  rms_busy_timer #(.CYCLES(NV_WRITE_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start(nv_start), .busy(wip)
  );
endmodule

// File: rtl/rms_chk.sv
module rms_chk #(
  parameter int NV_WRITE_CYCLES = 2_500_000
) (
  input logic        clk,
  input logic        rst,
  input logic        cs_on,
  input logic        cs_end,
  input logic        spi_miso_oe,
  input logic [11:0] dac_code,
  input logic [7:0]  cfg_byte,
  input logic        commit_go,
  input logic        wip,
  input logic        gpm_we
);
  localparam int CW = $clog2(NV_WRITE_CYCLES + 2);

  logic [CW-1:0] run;
  always_ff @(posedge clk) begin
    if (rst)      run <= '0;
    else if (wip) run <= run + 1'b1;
    else          run <= '0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_byte == 8'h84 && dac_code == 12'h000 && !spi_miso_oe));

  // R2
  so_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cs_on) |-> !spi_miso_oe);

  // R7
  dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> $past(commit_go));

  // R9
  cfg_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_byte[7:5] <= 3'd5) && (cfg_byte[4:2] <= 3'd5) && (cfg_byte[1:0] != 2'b11));

  // R11
  wip_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(cs_end));

  // R11
  wip_len_chk: assert property (@(posedge clk) disable iff (rst)
    run <= CW'(NV_WRITE_CYCLES));

  // R13
  gpm_busy_chk: assert property (@(posedge clk) disable iff (rst)
    gpm_we |-> wip);
endmodule

bind spi_regmap_slave rms_chk #(.NV_WRITE_CYCLES(NV_WRITE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cs_on(cs_on), .cs_end(cs_end), .spi_miso_oe(spi_miso_oe),
  .dac_code(dac_code), .cfg_byte(cfg_byte), .commit_go(commit_go), .wip(wip), .gpm_we(gpm_we)
);

// File: tb/spi_regmap_slave_tb.sv
module spi_regmap_slave_tb;
  localparam int NV   = 400;
  localparam int HALF = 8;
  localparam logic [5:0] DEV  = 6'h15;
  localparam logic [7:0] ID_W = {1'b0, DEV, 1'b0};
  localparam logic [7:0] ID_R = {1'b0, DEV, 1'b1};
  localparam logic [7:0] ID_P = {1'b1, DEV, 1'b1};

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, nrdy = 1'b0;
  logic miso, miso_oe;
  logic [11:0] dac_code;
  logic [7:0]  cfg_byte;

  always #2 clk = ~clk;

  spi_regmap_slave #(.NV_WRITE_CYCLES(NV), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .dev_addr(DEV), .not_ready(nrdy),
    .dac_code(dac_code), .cfg_byte(cfg_byte)
  );

  int vectors = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] txq [16];
  logic [7:0] rxq [16];
  logic       oe_seen;
  logic       w;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_run(input int n, input int extra);
    oe_seen = 1'b0;
    csn = 1'b0;
    clks(HALF);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        mosi = txq[i][b];
        clks(HALF);
        rxq[i][b] = miso;
        if (i >= 1) oe_seen = oe_seen | miso_oe;
        sck = 1'b1;
        clks(HALF);
        sck = 1'b0;
      end
    end
    for (int e = 0; e < extra; e++) begin
      mosi = 1'b1;
      clks(HALF);
      sck = 1'b1;
      clks(HALF);
      sck = 1'b0;
    end
    clks(HALF);
    csn = 1'b1;
    clks(20);
  endtask

  task automatic wr(input logic [7:0] a, input int nd, input int extra);
    txq[0] = ID_W;
    txq[1] = a;
    spi_run(nd + 2, extra);
  endtask

  task automatic rd(input logic [7:0] a, input int nd);
    txq[0] = ID_R;
    txq[1] = a;
    for (int i = 2; i < 16; i++) txq[i] = 8'h00;
    spi_run(nd + 2, 0);
  endtask

  task automatic poll(output logic busy);
    txq[0] = ID_P;
    txq[1] = 8'h00;
    spi_run(2, 0);
    chk("R12 poll upper bits", {9'b0, rxq[1][7:1]}, 16'h0);
    busy = rxq[1][0];
  endtask

  task automatic wait_nv();
    clks(NV + 40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    clks(5);
    rst = 1'b0;
    clks(5);
    // R1 reset state
    chk("R1 dac_code", {4'b0, dac_code}, 16'h000);
    chk("R1 cfg_byte", {8'b0, cfg_byte}, 16'h84);
    chk("R2 oe idle", {15'b0, miso_oe}, 16'h0);
    rd(8'h3F, 1);
    chk("R1 selector", {8'b0, rxq[2]}, 16'h00);

    // R6 storage sweep: every page, full 8-byte writes
    for (int p = 0; p < 7; p++) begin
      for (int k = 0; k < 8; k++) txq[2 + k] = pat(p * 8 + k);
      wr(8'(p * 8), 8, 0);
      if (p == 0) begin
        poll(w);
        chk("R11 busy after store", {15'b0, w}, 16'h1);
      end
      wait_nv();
    end
    poll(w);
    chk("R11 busy cleared", {15'b0, w}, 16'h0);
    for (int c = 0; c < 7; c++) begin
      rd(8'(c * 8), 8);
      chk("R2 oe while reading", {15'b0, oe_seen}, 16'h1);
      for (int k = 0; k < 8; k++) chk("R5 sweep read", {8'b0, rxq[2 + k]}, {8'b0, pat(c * 8 + k)});
    end

    // R6 page wrap: 6 bytes from 0Dh
    for (int k = 0; k < 6; k++) txq[2 + k] = 8'hA0 + 8'(k);
    wr(8'h0D, 6, 0);
    wait_nv();
    rd(8'h08, 8);
    chk("R6 wrap 08", {8'b0, rxq[2]}, 16'hA3);
    chk("R6 wrap 09", {8'b0, rxq[3]}, 16'hA4);
    chk("R6 wrap 0A", {8'b0, rxq[4]}, 16'hA5);
    chk("R6 wrap 0B", {8'b0, rxq[5]}, {8'b0, pat(11)});
    chk("R6 wrap 0C", {8'b0, rxq[6]}, {8'b0, pat(12)});
    chk("R6 wrap 0D", {8'b0, rxq[7]}, 16'hA0);
    chk("R6 wrap 0F", {8'b0, rxq[9]}, 16'hA2);

    // R6 overwrite: 10 bytes from 10h
    for (int k = 0; k < 10; k++) txq[2 + k] = 8'hC0 + 8'(k);
    wr(8'h10, 10, 0);
    wait_nv();
    rd(8'h10, 8);
    chk("R6 overwrite 10", {8'b0, rxq[2]}, 16'hC8);
    chk("R6 overwrite 11", {8'b0, rxq[3]}, 16'hC9);
    for (int k = 2; k < 8; k++) chk("R6 overwrite rest", {8'b0, rxq[2 + k]}, {8'b0, 8'hC0 + 8'(k)});

    // R5 rollover 3Eh -> 3Fh -> 00h -> 01h
    rd(8'h3E, 4);
    chk("R5 roll 3E", {8'b0, rxq[2]}, 16'h00);
    chk("R5 roll 3F", {8'b0, rxq[3]}, 16'h00);
    chk("R5 roll 00", {8'b0, rxq[4]}, {8'b0, pat(0)});
    chk("R5 roll 01", {8'b0, rxq[5]}, {8'b0, pat(1)});

    // R13 write ignored during busy, read served
    txq[2] = 8'h11;
    wr(8'h20, 1, 0);
    txq[2] = 8'h22;
    wr(8'h21, 1, 0);
    rd(8'h20, 2);
    chk("R13 read during busy", {8'b0, rxq[2]}, 16'h11);
    chk("R13 write blocked", {8'b0, rxq[3]}, {8'b0, pat(8'h21)});
    wait_nv();

    // R3 address mismatch
    txq[0] = {1'b0, 6'h14, 1'b0};
    txq[1] = 8'h30;
    txq[2] = 8'hEE;
    spi_run(3, 0);
    rd(8'h30, 1);
    chk("R3 mismatch ignored", {8'b0, rxq[2]}, {8'b0, pat(8'h30)});
    poll(w);
    chk("R3 mismatch no busy", {15'b0, w}, 16'h0);

    // R4 address out of range
    txq[2] = 8'h77;
    wr(8'h45, 1, 0);
    rd(8'h05, 1);
    chk("R4 abort no write", {8'b0, rxq[2]}, {8'b0, pat(5)});
    poll(w);
    chk("R4 abort no busy", {15'b0, w}, 16'h0);

    // R2 not_ready blocks commands
    nrdy = 1'b1;
    txq[2] = 8'h55;
    wr(8'h00, 1, 0);
    nrdy = 1'b0;
    rd(8'h00, 1);
    chk("R2 not_ready ignored", {8'b0, rxq[2]}, {8'b0, pat(0)});

    // R6 partial byte discarded
    txq[2] = 8'h33;
    wr(8'h06, 1, 3);
    rd(8'h06, 1);
    chk("R6 partial discarded", {8'b0, rxq[2]}, {8'b0, pat(6)});

    // R7 DAC pair
    txq[2] = 8'hAB;
    txq[3] = 8'hCF;
    wr(8'h38, 2, 0);
    chk("R7 dac_code", {4'b0, dac_code}, 16'hABC);
    poll(w);
    chk("R11 volatile no busy", {15'b0, w}, 16'h0);
    rd(8'h38, 2);
    chk("R7 read 38", {8'b0, rxq[2]}, 16'hAB);
    chk("R7 read 39", {8'b0, rxq[3]}, 16'hC0);
    txq[2] = 8'h12;
    wr(8'h38, 1, 0);
    chk("R7 single byte", {4'b0, dac_code}, 16'hABC);
    txq[2] = 8'h12; txq[3] = 8'h34; txq[4] = 8'h56;
    wr(8'h38, 3, 0);
    chk("R7 three bytes", {4'b0, dac_code}, 16'hABC);
    txq[2] = 8'h12; txq[3] = 8'h00;
    wr(8'h39, 2, 0);
    chk("R7 pair from 39", {4'b0, dac_code}, 16'hABC);

    // R8 selector
    txq[2] = 8'h80;
    wr(8'h3F, 1, 0);
    rd(8'h3F, 1);
    chk("R8 selector set", {8'b0, rxq[2]}, 16'h80);
    txq[2] = 8'h5A;
    txq[3] = 8'h30;
    wr(8'h38, 2, 0);
    chk("R8 dac_code untouched", {4'b0, dac_code}, 16'hABC);
    poll(w);
    chk("R11 initial code busy", {15'b0, w}, 16'h1);
    wait_nv();
    rd(8'h38, 2);
    chk("R8 initial hi", {8'b0, rxq[2]}, 16'h5A);
    chk("R8 initial lo", {8'b0, rxq[3]}, 16'h30);
    txq[2] = 8'h40;
    wr(8'h3F, 1, 0);
    rd(8'h3F, 1);
    chk("R8 bad value ignored", {8'b0, rxq[2]}, 16'h80);
    txq[2] = 8'h00;
    wr(8'h3F, 1, 0);
    rd(8'h38, 1);
    chk("R8 selector clear", {8'b0, rxq[2]}, 16'hAB);

    // R9 configuration byte
    txq[2] = 8'hA4;
    wr(8'h3C, 1, 0);
    chk("R9 cfg load", {8'b0, cfg_byte}, 16'hA4);
    poll(w);
    chk("R11 cfg busy", {15'b0, w}, 16'h1);
    wait_nv();
    txq[2] = 8'hC4;
    wr(8'h3C, 1, 0);
    chk("R9 VH 110 rejected", {8'b0, cfg_byte}, 16'hA4);
    txq[2] = 8'h1C;
    wr(8'h3C, 1, 0);
    chk("R9 VL 111 rejected", {8'b0, cfg_byte}, 16'hA4);
    txq[2] = 8'hA7;
    wr(8'h3C, 1, 0);
    chk("R9 step 11 rejected", {8'b0, cfg_byte}, 16'hA4);
    txq[2] = 8'h24; txq[3] = 8'h00;
    wr(8'h3C, 2, 0);
    chk("R9 two bytes rejected", {8'b0, cfg_byte}, 16'hA4);
    txq[2] = 8'h25;
    wr(8'h3C, 1, 0);
    chk("R9 cfg reload", {8'b0, cfg_byte}, 16'h25);
    wait_nv();

    // R10 reserved bytes
    txq[2] = 8'h99;
    wr(8'h3A, 1, 0);
    txq[2] = 8'h99;
    wr(8'h3D, 1, 0);
    rd(8'h3A, 4);
    chk("R10 3A reads 0", {8'b0, rxq[2]}, 16'h00);
    chk("R10 3B reads 0", {8'b0, rxq[3]}, 16'h00);
    chk("R10 3C kept", {8'b0, rxq[4]}, 16'h25);
    chk("R10 3D reads 0", {8'b0, rxq[5]}, 16'h00);
    poll(w);
    chk("R10 no busy", {15'b0, w}, 16'h0);
    chk("R2 oe idle end", {15'b0, miso_oe}, 16'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule